// File: doc/BRIEF.md
# Bus Cycle Sequencer for a Processor Core

This block sits between a processor's internal engines and a 32-bit Wishbone master port. A requester offers one transaction at a time: an instruction fetch, a data read, a data write, an indivisible read-then-write (for test-and-set), or an interrupt acknowledge. Each request carries a word address, byte enables, a supervisor flag, a beat count for bursts, write data and an interrupt level. The sequencer raises the bus cycle and attaches the cycle tags. It holds the cycle through retries and ends it on acknowledge or error. It then reports the outcome with a one-clock done pulse and a status code.

Read data comes back with a one-clock beat pulse for every acknowledged read beat. An interrupt acknowledge returns either the vector byte, an autovector request or a spurious-interrupt status. The retry and error inputs are decoded by cycle type. The function code on every cycle comes from the request kind and privilege level.

Top module: `wbm_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, `cyc_o` and `stb_o` are low, `done` and `beat_valid` are low and `req_ready` is high.
- R2: A request accepted in an idle cycle raises `cyc_o` and `stb_o` in the next cycle. They stay high until a termination. For a write, `we_o` is 1 and `dat_o` carries the request data; `sel_o` equals the request byte enables. An acknowledge ends the cycle: in the next cycle `cyc_o` is low and `done` is high with status 0 (ok). A read also returns the data input in `rdata` with `beat_valid` high.
- R3: On a memory cycle, a retry keeps `cyc_o` high with the same address and write enable, and it gives no `done`. The same beat is then presented again.
- R4: On a memory cycle, an error ends the cycle: in the next cycle `cyc_o` is low and `done` is high with status 1 (bus error).
- R5: A fetch or read with a nonzero `req_len` is a burst of `req_len`+1 beats with `blk_o` high and `bte_o` = 00. `cti_o` is 010 on every beat but the last and 111 on the last. The word address rises by one after each acknowledged beat and stays put after a retry, and each acknowledged beat pulses `beat_valid` with its data.
- R6: A read-modify-write request keeps `rmw_o` and `cyc_o` high across a read phase (`we_o` = 0) and then a write phase (`we_o` = 1) at the same address. A retry in the write phase repeats only the write, with no further read beat.
- R7: An interrupt acknowledge drives `adr_o` with all upper bits one and the low 3 bits equal to `req_ipl`, with `sel_o` = 1111 and `fc_o` = 7. Acknowledge returns status 2 with `vector` = data input bits 7..0. Retry returns status 3 (autovector), and error returns status 4 (spurious).
- R8: `fc_o` is 1 for user reads and writes, 2 for user fetches, 5 for supervisor reads and writes, and 6 for supervisor fetches. Request kinds are encoded as: 0 fetch, 1 read, 2 write, 3 read-modify-write, 4 interrupt acknowledge.
- R9: `done` is a one-cycle pulse and coincides with `cyc_o` low, so separate cycles are parted by at least one idle clock.
- R10: Non-burst fetches, reads and writes assert `sgl_o` with `blk_o` and `rmw_o` low and `cti_o` = 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_kind | input | 3 | Request kind (see R8) |
| req_addr | input | 30 | Word address |
| req_sel | input | 4 | Byte enables |
| req_len | input | 4 | Extra burst beats (fetch/read only) |
| req_sup | input | 1 | Supervisor privilege |
| req_wdata | input | 32 | Write data |
| req_ipl | input | 3 | Interrupt level for acknowledge |
| done | output | 1 | Transaction finished pulse |
| status | output | 3 | Outcome code, valid with done |
| beat_valid | output | 1 | Read beat data valid pulse |
| rdata | output | 32 | Read beat data |
| vector | output | 8 | Interrupt vector byte |
| cyc_o | output | 1 | Bus cycle |
| stb_o | output | 1 | Strobe |
| we_o | output | 1 | Write enable |
| sel_o | output | 4 | Byte selects |
| adr_o | output | 30 | Word address |
| dat_o | output | 32 | Write data |
| dat_i | input | 32 | Read data |
| ack_i | input | 1 | Acknowledge termination |
| err_i | input | 1 | Error termination |
| rty_i | input | 1 | Retry termination |
| sgl_o | output | 1 | Single-cycle tag |
| blk_o | output | 1 | Block-cycle tag |
| rmw_o | output | 1 | Read-modify-write tag |
| cti_o | output | 3 | Cycle type identifier |
| bte_o | output | 2 | Burst type extension |
| fc_o | output | 3 | Function code |

## Verification
The properties assume that the slave raises at most one of acknowledge, retry and error in a cycle. They also assume that a termination arrives only while the cycle is open. The bench drives a single termination per cycle and raises it only after the cycle is seen open. It keeps random addresses well clear of the top of the address space, so a burst never wraps. A new request is offered only once the previous done has been seen.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
    localparam int ADDR_W_DEF = 30;
    localparam int DATA_W_DEF = 32;
    localparam int LEN_W_DEF  = 4;
    localparam int IPL_W      = 3;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_READ  = 3'd1,
        K_WRITE = 3'd2,
        K_RMW   = 3'd3,
        K_IACK  = 3'd4
    } kind_t;

    typedef enum logic [2:0] {
        ST_OK       = 3'd0,
        ST_BUSERR   = 3'd1,
        ST_VECTOR   = 3'd2,
        ST_AUTOVEC  = 3'd3,
        ST_SPURIOUS = 3'd4
    } stat_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_RMWW = 2'd2
    } state_t;

    typedef struct packed {
        kind_t              kind;
        logic               sup;
        logic               burst;
        logic [IPL_W-1:0]   ipl;
    } ctl_t;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [2:0] CTI_INCR    = 3'b010;
    localparam logic [2:0] CTI_EOB     = 3'b111;
    localparam logic [1:0] BTE_LINEAR  = 2'b00;

    // privilege in the top bit, program/data space in the low two bits
    function automatic logic [2:0] fc_code(input kind_t k, input logic sup);
        if (k == K_IACK) return 3'b111;
        return {sup, k == K_FETCH, k != K_FETCH};
    endfunction
endpackage

// File: rtl/wbm_beat_ctr.sv
module wbm_beat_ctr #(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= addr_in;
            remain <= len_in;
        end else if (advance) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == '0);
endmodule

// File: rtl/wbm_tags.sv
module wbm_tags
    import wbm_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int SEL_W  = 4
) (
    input  ctl_t              ctl,
    input  logic              last,
    input  logic              wr_phase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  sel_in,
    output logic [ADDR_W-1:0] adr_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [2:0]        fc_o,
    output logic              we_o,
    output logic              sgl_o,
    output logic              blk_o,
    output logic              rmw_o,
    output logic [2:0]        cti_o,
    output logic [1:0]        bte_o
);
    logic is_iack;

    always_comb begin
        is_iack = (ctl.kind == K_IACK);
        adr_o   = is_iack ? {{(ADDR_W-IPL_W){1'b1}}, ctl.ipl} : addr;
        sel_o   = is_iack ? {SEL_W{1'b1}} : sel_in;
        fc_o    = fc_code(ctl.kind, ctl.sup);
        we_o    = (ctl.kind == K_WRITE) || ((ctl.kind == K_RMW) && wr_phase);
        rmw_o   = (ctl.kind == K_RMW);
        blk_o   = ctl.burst;
        sgl_o   = !ctl.burst && !rmw_o && !is_iack;
        cti_o   = ctl.burst ? (last ? CTI_EOB : CTI_INCR) : CTI_CLASSIC;
        bte_o   = BTE_LINEAR;
    end
endmodule

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
    import wbm_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int LEN_W  = LEN_W_DEF,
    localparam int SEL_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_sup,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [IPL_W-1:0]  req_ipl,
    output logic              done,
    output logic [2:0]        status,
    output logic              beat_valid,
    output logic [DATA_W-1:0] rdata,
    output logic [7:0]        vector,
    output logic              cyc_o,
    output logic              stb_o,
    output logic              we_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [ADDR_W-1:0] adr_o,
    output logic [DATA_W-1:0] dat_o,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              ack_i,
    input  logic              err_i,
    input  logic              rty_i,
    output logic              sgl_o,
    output logic              blk_o,
    output logic              rmw_o,
    output logic [2:0]        cti_o,
    output logic [1:0]        bte_o,
    output logic [2:0]        fc_o
);
    state_t             state;
    ctl_t               ctl;
    logic [SEL_W-1:0]   sel_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [ADDR_W-1:0]  cur_addr;
    logic               last;
    logic               accept;
    logic               advance;
    logic               burst_in;
    kind_t              kind_in;

    assign kind_in   = kind_t'(req_kind);
    assign req_ready = (state == S_IDLE);
    assign accept    = req_ready && req_valid;
    assign burst_in  = ((kind_in == K_FETCH) || (kind_in == K_READ)) && (req_len != '0);
    assign advance   = (state == S_XFER) && ack_i && !err_i && ctl.burst && !last;

    wbm_beat_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .addr_in (req_addr),
        .len_in  (burst_in ? req_len : '0),
        .advance (advance),
        .addr    (cur_addr),
        .last    (last)
    );

    wbm_tags #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_tags (
        .ctl      (ctl),
        .last     (last),
        .wr_phase (state == S_RMWW),
        .addr     (cur_addr),
        .sel_in   (sel_q),
        .adr_o    (adr_o),
        .sel_o    (sel_o),
        .fc_o     (fc_o),
        .we_o     (we_o),
        .sgl_o    (sgl_o),
        .blk_o    (blk_o),
        .rmw_o    (rmw_o),
        .cti_o    (cti_o),
        .bte_o    (bte_o)
    );

    assign cyc_o = (state != S_IDLE);
    assign stb_o = cyc_o;
    assign dat_o = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            ctl        <= '{kind: K_READ, sup: 1'b0, burst: 1'b0, ipl: '0};
            sel_q      <= '0;
            wdata_q    <= '0;
            done       <= 1'b0;
            status     <= ST_OK;
            beat_valid <= 1'b0;
            rdata      <= '0;
            vector     <= '0;
        end else begin
            done       <= 1'b0;
            beat_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        ctl     <= '{kind: kind_in, sup: req_sup, burst: burst_in, ipl: req_ipl};
                        sel_q   <= req_sel;
                        wdata_q <= req_wdata;
                        state   <= S_XFER;
                    end
                end
                S_XFER: begin
                    if (ctl.kind == K_IACK) begin
                        if (err_i || ack_i || rty_i) begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                        if (err_i)      status <= ST_SPURIOUS;
                        else if (ack_i) begin
                            status <= ST_VECTOR;
                            vector <= dat_i[7:0];
                        end
                        else if (rty_i) status <= ST_AUTOVEC;
                    end else if (err_i) begin
                        done   <= 1'b1;
                        status <= ST_BUSERR;
                        state  <= S_IDLE;
                    end else if (ack_i) begin
                        if (ctl.kind != K_WRITE) begin
                            rdata      <= dat_i;
                            beat_valid <= 1'b1;
                        end
                        if (ctl.kind == K_RMW) begin
                            state <= S_RMWW;
                        end else if (last) begin
                            done   <= 1'b1;
                            status <= ST_OK;
                            state  <= S_IDLE;
                        end
                    end
                end
                S_RMWW: begin
                    if (err_i || ack_i) begin
                        done   <= 1'b1;
                        status <= err_i ? ST_BUSERR : ST_OK;
                        state  <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wbm_ctrl_chk.sv
module wbm_ctrl_chk #(
    parameter int ADDR_W = 30,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [2:0]        status,
    input logic              cyc_o,
    input logic              we_o,
    input logic [SEL_W-1:0]  sel_o,
    input logic [ADDR_W-1:0] adr_o,
    input logic              ack_i,
    input logic              err_i,
    input logic              rty_i,
    input logic              blk_o,
    input logic              rmw_o,
    input logic [2:0]        cti_o,
    input logic [2:0]        fc_o
);
    p_hold_retry_r3: assert property (@(posedge clk) disable iff (rst)
        cyc_o && rty_i && !ack_i && !err_i && fc_o != 3'd7
        |=> cyc_o && $stable(adr_o) && $stable(we_o) && !done);

    p_err_end_r4: assert property (@(posedge clk) disable iff (rst)
        cyc_o && err_i && fc_o != 3'd7 |=> !cyc_o && done && status == 3'd1);

    p_burst_step_r5: assert property (@(posedge clk) disable iff (rst)
        cyc_o && blk_o && ack_i && !err_i && cti_o == 3'b010
        |=> cyc_o && blk_o && adr_o == $past(adr_o) + 1'b1);

    p_rmw_phase_r6: assert property (@(posedge clk) disable iff (rst)
        cyc_o && rmw_o && ack_i && !err_i && !we_o
        |=> cyc_o && rmw_o && we_o && $stable(adr_o));

    p_iack_bus_r7: assert property (@(posedge clk) disable iff (rst)
        cyc_o && fc_o == 3'd7 |-> (&adr_o[ADDR_W-1:3]) && (&sel_o));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !cyc_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind wbm_ctrl wbm_ctrl_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .status (status),
    .cyc_o  (cyc_o),
    .we_o   (we_o),
    .sel_o  (sel_o),
    .adr_o  (adr_o),
    .ack_i  (ack_i),
    .err_i  (err_i),
    .rty_i  (rty_i),
    .blk_o  (blk_o),
    .rmw_o  (rmw_o),
    .cti_o  (cti_o),
    .fc_o   (fc_o)
);

// File: tb/tb_wbm_ctrl.sv
module tb_wbm_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd1;
    logic [29:0] req_addr = '0;
    logic [3:0]  req_sel = '0;
    logic [3:0]  req_len = '0;
    logic        req_sup = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_ipl = '0;
    logic        done, beat_valid;
    logic [2:0]  status;
    logic [31:0] rdata;
    logic [7:0]  vector;
    logic        cyc_o, stb_o, we_o;
    logic [3:0]  sel_o;
    logic [29:0] adr_o;
    logic [31:0] dat_o;
    logic [31:0] dat_i = '0;
    logic        ack_i = 1'b0, err_i = 1'b0, rty_i = 1'b0;
    logic        sgl_o, blk_o, rmw_o;
    logic [2:0]  cti_o, fc_o;
    logic [1:0]  bte_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wbm_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_sel(req_sel), .req_len(req_len),
        .req_sup(req_sup), .req_wdata(req_wdata), .req_ipl(req_ipl),
        .done(done), .status(status), .beat_valid(beat_valid), .rdata(rdata),
        .vector(vector), .cyc_o(cyc_o), .stb_o(stb_o), .we_o(we_o), .sel_o(sel_o),
        .adr_o(adr_o), .dat_o(dat_o), .dat_i(dat_i), .ack_i(ack_i), .err_i(err_i),
        .rty_i(rty_i), .sgl_o(sgl_o), .blk_o(blk_o), .rmw_o(rmw_o), .cti_o(cti_o),
        .bte_o(bte_o), .fc_o(fc_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_fc(input logic [2:0] k, input logic sup);
        if (k == 3'd4) return 3'd7;
        if (k == 3'd0) return sup ? 3'd6 : 3'd2;
        return sup ? 3'd5 : 3'd1;
    endfunction

    task automatic start(input logic [2:0] k, input logic [29:0] a, input logic [3:0] s,
                         input logic [3:0] len, input logic sup, input logic [31:0] wd,
                         input logic [2:0] ipl);
        @(negedge clk);
        req_kind = k; req_addr = a; req_sel = s; req_len = len;
        req_sup = sup; req_wdata = wd; req_ipl = ipl; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic resp(input logic a, input logic r, input logic e, input logic [31:0] d);
        @(negedge clk);
        ack_i = a; rty_i = r; err_i = e; dat_i = d;
        @(posedge clk); #1;
        ack_i = 1'b0; rty_i = 1'b0; err_i = 1'b0;
    endtask

    task automatic do_mem(input logic [2:0] k, input logic [29:0] a, input logic [3:0] len,
                          input logic sup);
        int beats;
        bit erred;
        logic [31:0] wd;
        beats = (k == 3'd2) ? 1 : int'(len) + 1;
        erred = 1'b0;
        wd = $urandom;
        start(k, a, 4'hF, (k == 3'd2) ? 4'd0 : len, sup, wd, 3'd0);
        for (int b = 0; b < beats && !erred; b++) begin
            int nr;
            logic [31:0] d;
            nr = $urandom % 3;
            check("R5 beat address", adr_o, 30'(a + 30'(b)));
            check("R8 function code", fc_o, exp_fc(k, sup));
            if (beats > 1)
                check("R5 burst tags", {blk_o, sgl_o, cti_o, bte_o},
                      {1'b1, 1'b0, (b == beats - 1) ? 3'b111 : 3'b010, 2'b00});
            else
                check("R10 single tags", {sgl_o, blk_o, rmw_o, cti_o}, {3'b100, 3'b000});
            if (k == 3'd2) check("R2 write data", {we_o, dat_o}, {1'b1, wd});
            repeat (nr) begin
                resp(1'b0, 1'b1, 1'b0, 32'h0);
                check("R3 retry holds", {cyc_o, done, beat_valid, adr_o},
                      {3'b100, 30'(a + 30'(b))});
            end
            if ($urandom % 10 == 0) begin
                resp(1'b0, 1'b0, 1'b1, 32'h0);
                check("R4 bus error", {cyc_o, done, status}, {2'b01, 3'd1});
                erred = 1'b1;
            end else begin
                d = $urandom;
                resp(1'b1, 1'b0, 1'b0, d);
                if (k != 3'd2) check("R5 beat data", {beat_valid, rdata}, {1'b1, d});
            end
        end
        if (!erred) check("R2 done ok", {cyc_o, done, status}, {2'b01, 3'd0});
        @(posedge clk); #1;
        check("R9 done pulse", done, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed_r;
        seed_r = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {cyc_o, stb_o, done, beat_valid, req_ready}, 5'b00001);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", {cyc_o, stb_o, done, req_ready}, 4'b0001);

        // single user read
        start(3'd1, 30'h123, 4'h6, 4'd0, 1'b0, 32'h0, 3'd0);
        check("R2 cycle open", {cyc_o, stb_o, we_o, adr_o, sel_o}, {3'b110, 30'h123, 4'h6});
        check("R8 user data fc", fc_o, 3'd1);
        check("R10 single tags", {sgl_o, blk_o, rmw_o, cti_o}, {3'b100, 3'b000});
        resp(1'b1, 1'b0, 1'b0, 32'hCAFE_0001);
        check("R2 read done", {cyc_o, done, status, beat_valid, rdata},
              {2'b01, 3'd0, 1'b1, 32'hCAFE_0001});
        @(posedge clk); #1;
        check("R9 done one cycle", {done, cyc_o}, 2'b00);

        // supervisor write with retries
        start(3'd2, 30'h0AB, 4'h3, 4'd0, 1'b1, 32'hDEAD_BEEF, 3'd0);
        check("R2 write bus", {we_o, dat_o, sel_o}, {1'b1, 32'hDEAD_BEEF, 4'h3});
        check("R8 super data fc", fc_o, 3'd5);
        resp(1'b0, 1'b1, 1'b0, 32'h0);
        check("R3 retry one", {cyc_o, we_o, done, adr_o}, {3'b110, 30'h0AB});
        resp(1'b0, 1'b1, 1'b0, 32'h0);
        check("R3 retry two", {cyc_o, we_o, done, adr_o}, {3'b110, 30'h0AB});
        resp(1'b1, 1'b0, 1'b0, 32'h0);
        check("R2 write done", {cyc_o, done, status, beat_valid}, {2'b01, 3'd0, 1'b0});

        // error on a read
        start(3'd1, 30'h055, 4'hF, 4'd0, 1'b0, 32'h0, 3'd0);
        resp(1'b0, 1'b0, 1'b1, 32'h0);
        check("R4 read error", {cyc_o, done, status}, {2'b01, 3'd1});

        // fetch codes
        start(3'd0, 30'h010, 4'hF, 4'd0, 1'b1, 32'h0, 3'd0);
        check("R8 super program fc", fc_o, 3'd6);
        resp(1'b1, 1'b0, 1'b0, 32'h1);
        start(3'd0, 30'h020, 4'hF, 4'd0, 1'b0, 32'h0, 3'd0);
        check("R8 user program fc", fc_o, 3'd2);
        resp(1'b1, 1'b0, 1'b0, 32'h2);

        // directed burst of 4 with a retry on beat 1
        start(3'd1, 30'h100, 4'hF, 4'd3, 1'b0, 32'h0, 3'd0);
        check("R5 first beat", {blk_o, sgl_o, cti_o, bte_o, adr_o}, {2'b10, 3'b010, 2'b00, 30'h100});
        resp(1'b1, 1'b0, 1'b0, 32'hB000_0000);
        check("R5 beat 0 data", {beat_valid, done, rdata, adr_o}, {2'b10, 32'hB000_0000, 30'h101});
        resp(1'b0, 1'b1, 1'b0, 32'h0);
        check("R5 retry no advance", {beat_valid, adr_o, cti_o}, {1'b0, 30'h101, 3'b010});
        resp(1'b1, 1'b0, 1'b0, 32'hB000_0001);
        resp(1'b1, 1'b0, 1'b0, 32'hB000_0002);
        check("R5 last beat eob", {adr_o, cti_o}, {30'h103, 3'b111});
        resp(1'b1, 1'b0, 1'b0, 32'hB000_0003);
        check("R5 burst done", {cyc_o, done, status, rdata}, {2'b01, 3'd0, 32'hB000_0003});

        // read-modify-write with retry in write phase
        start(3'd3, 30'h0F0, 4'h8, 4'd2, 1'b1, 32'h8000_0000, 3'd0);
        check("R6 read phase", {rmw_o, sgl_o, blk_o, we_o, fc_o}, {4'b1000, 3'd5});
        resp(1'b1, 1'b0, 1'b0, 32'h0000_0011);
        check("R6 write phase", {cyc_o, rmw_o, we_o, done, beat_valid, rdata, adr_o},
              {5'b11101, 32'h0000_0011, 30'h0F0});
        resp(1'b0, 1'b1, 1'b0, 32'h0);
        check("R6 retry write only", {cyc_o, we_o, beat_valid, done, adr_o}, {4'b1100, 30'h0F0});
        resp(1'b1, 1'b0, 1'b0, 32'h0);
        check("R6 rmw done", {cyc_o, done, status}, {2'b01, 3'd0});

        // interrupt acknowledge outcomes
        start(3'd4, 30'h0, 4'h0, 4'd0, 1'b1, 32'h0, 3'd5);
        check("R7 iack bus", {adr_o, sel_o, fc_o}, {{27{1'b1}}, 3'd5, 4'hF, 3'd7});
        resp(1'b1, 1'b0, 1'b0, 32'h1234_56A7);
        check("R7 vector", {done, status, vector}, {1'b1, 3'd2, 8'hA7});
        start(3'd4, 30'h0, 4'h0, 4'd0, 1'b1, 32'h0, 3'd2);
        check("R7 iack level", adr_o, {{27{1'b1}}, 3'd2});
        resp(1'b0, 1'b1, 1'b0, 32'h0);
        check("R7 autovector", {cyc_o, done, status}, {2'b01, 3'd3});
        start(3'd4, 30'h0, 4'h0, 4'd0, 1'b0, 32'h0, 3'd7);
        resp(1'b0, 1'b0, 1'b1, 32'h0);
        check("R7 spurious", {cyc_o, done, status}, {2'b01, 3'd4});

        // constrained random memory traffic
        for (int i = 0; i < 40; i++) begin
            logic [2:0] k;
            k = 3'($urandom % 3);
            do_mem(k, 30'($urandom % 32'h1000_0000), 4'($urandom % 4), 1'($urandom % 2));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule